// File: doc/BRIEF.md
# Delayed Read Target Buffer

This block is a simplified host-side target that serves memory reads from a bus master by splitting each read into a delayed request and a later completion. When a read attempt arrives for an address the block does not hold, it answers with a retry and records the starting address. It then fetches a fixed-size block of words from a memory-side port while the master keeps retrying. Once the block is filled, the next attempt at the recorded address is accepted and words are returned, one per beat.

The target does not know how many words the master wants. The master either marks its final beat, or the target disconnects it when the buffered words run out. Either way the buffer is released. A buffer that nobody collects is dropped after a fixed idle time. Counters of retries, accepted completions and disconnects are exported so that throughput can be measured. Both sides use a simple per-beat handshake and do not model bus pin timing.

Top module: `delayed_read_target`

## Requirements
- R1: When no transaction is held, a beat with reqStart=1 is answered with retry (rspKind=2), and in the following cycle memReqValid rises with memReqAddr equal to that beat's reqAddr.
- R2: One fetch is a single request that stays asserted with a stable address until memReqReady. Then PREFETCH_BYTES/4 response beats are stored in arrival order, and no further request is raised for that transaction.
- R3: While a fetch is in progress, every request beat is answered with retry, whatever its address. The fetch in flight and its address are not changed.
- R4: When the fetch is complete, a start beat whose address equals the recorded address is answered with data (rspKind=1), and rspData is the first fetched word.
- R5: Continuation beats (reqStart=0) return the following fetched words in order. Once all PREFETCH_BYTES/4 words have been delivered, the next continuation beat is answered with disconnect (rspKind=3).
- R6: After a disconnect, a start beat at the next address (recorded address + PREFETCH_BYTES) is retried and begins a new fetch at that address.
- R7: While a filled buffer waits, a start beat at a different address is retried, starts no fetch, and leaves the buffer available for the recorded address.
- R8: A data beat with reqLast=1 ends the transaction. A later start beat at the same address is retried and fetches again.
- R9: A filled buffer is still served after fewer than DISCARD_CYCLES idle cycles. After DISCARD_CYCLES cycles without an accepted start it is dropped, so the next attempt is retried and fetches again.
- R10: cntRetry, cntDone and cntDisc each add one for every retry beat, every accepted start data beat and every disconnect beat, respectively.
- R11: After reset, memReqValid is 0 and all three counters are 0.
- R12: rspKind is 0 (none) in any cycle without reqValid. A continuation beat while no transaction is held is retried and starts no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Initiator beat present |
| reqStart | input | 1 | Beat opens a new attempt |
| reqLast | input | 1 | Beat is the initiator's final beat |
| reqAddr | input | ADDR_W | Byte address of the attempt |
| rspKind | output | 2 | 0 none, 1 data, 2 retry, 3 disconnect |
| rspData | output | DATA_W | Word returned on a data beat |
| memReqValid | output | 1 | Fetch request to memory |
| memReqAddr | output | ADDR_W | Fetch start address |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Fetched word present |
| memRspData | input | DATA_W | Fetched word |
| cntRetry | output | CNT_W | Retries issued |
| cntDone | output | CNT_W | Completions accepted |
| cntDisc | output | CNT_W | Disconnects issued |

## Verification
The bench targets these corner cases:
- Retries at a foreign address during a fetch and during the waiting state. A design that latched those addresses would fetch or serve the wrong block.
- The last buffered word and the beat after it. An off-by-one would either return a stale word or disconnect one beat early.
- The discard timer, checked on both sides of its limit. It catches a buffer that is dropped too soon or never dropped.
- A stray continuation beat with no transaction held. A design that latched on it would start a spurious fetch.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_RETRY = 2'd2,
    RSP_DISC  = 2'd3
  } rspKind_e;

  typedef struct packed {
    logic latchAddr;  // record start address, clear pointers
    logic fillWr;     // store one fetched word
    logic rdInc;      // advance the read pointer
  } dpStrobe_t;
endpackage

// File: rtl/drt_datapath.sv
module drt_datapath
  import drt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  localparam int PTR_W = $clog2(WORDS + 1),
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] pendAddr,
  output logic              addrMatch,
  output logic              fillLast,
  output logic              rdEmpty,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bufMem [WORDS];
  logic [PTR_W-1:0]  fillPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      fillPtr  <= '0;
      rdPtr    <= '0;
    end else begin
      if (strobe.latchAddr) begin
        pendAddr <= reqAddr;
        fillPtr  <= '0;
        rdPtr    <= '0;
      end else begin
        if (strobe.fillWr) fillPtr <= fillPtr + 1'b1;
        if (strobe.rdInc)  rdPtr   <= rdPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWr) bufMem[fillPtr[IDX_W-1:0]] <= memRspData;
  end

  assign addrMatch = (reqAddr == pendAddr);
  assign fillLast  = (fillPtr == PTR_W'(WORDS - 1));
  assign rdEmpty   = (rdPtr == PTR_W'(WORDS));
  assign rdData    = bufMem[rdPtr[IDX_W-1:0]];
endmodule

// File: rtl/drt_ctrl.sv
module drt_ctrl
  import drt_pkg::*;
#(
  parameter int DISCARD_CYCLES = 1024,
  parameter int CNT_W          = 16,
  localparam int TMR_W = $clog2(DISCARD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqStart,
  input  logic             reqLast,
  input  logic             addrMatch,
  input  logic             fillLast,
  input  logic             rdEmpty,
  input  logic             memReqReady,
  input  logic             memRspValid,
  output dpStrobe_t        strobe,
  output rspKind_e         rspKind,
  output logic             memReqValid,
  output logic [CNT_W-1:0] cntRetry,
  output logic [CNT_W-1:0] cntDone,
  output logic [CNT_W-1:0] cntDisc
);
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_FILL, ST_READY, ST_ACTIVE} state_e;

  state_e           state, stateNxt;
  logic [TMR_W-1:0] idleTmr;
  logic             acceptStart;

  always_comb begin
    stateNxt    = state;
    rspKind     = RSP_NONE;
    strobe      = '0;
    acceptStart = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          rspKind = RSP_RETRY;
          if (reqStart) begin
            strobe.latchAddr = 1'b1;
            stateNxt         = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (reqValid) rspKind = RSP_RETRY;
        if (memReqReady) stateNxt = ST_FILL;
      end
      ST_FILL: begin
        if (reqValid) rspKind = RSP_RETRY;
        if (memRspValid) begin
          strobe.fillWr = 1'b1;
          if (fillLast) stateNxt = ST_READY;
        end
      end
      ST_READY: begin
        if (reqValid && reqStart && addrMatch) begin
          rspKind      = RSP_DATA;
          strobe.rdInc = 1'b1;
          acceptStart  = 1'b1;
          stateNxt     = reqLast ? ST_IDLE : ST_ACTIVE;
        end else begin
          if (reqValid) rspKind = RSP_RETRY;
          if (idleTmr == TMR_W'(DISCARD_CYCLES - 1)) stateNxt = ST_IDLE;
        end
      end
      ST_ACTIVE: begin
        if (reqValid) begin
          if (reqStart) begin
            rspKind = RSP_RETRY;
          end else if (rdEmpty) begin
            rspKind  = RSP_DISC;
            stateNxt = ST_IDLE;
          end else begin
            rspKind      = RSP_DATA;
            strobe.rdInc = 1'b1;
            if (reqLast) stateNxt = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idleTmr  <= '0;
      cntRetry <= '0;
      cntDone  <= '0;
      cntDisc  <= '0;
    end else begin
      state   <= stateNxt;
      idleTmr <= (state == ST_READY && stateNxt == ST_READY) ? idleTmr + 1'b1 : '0;
      if (rspKind == RSP_RETRY) cntRetry <= cntRetry + 1'b1;
      if (acceptStart)          cntDone  <= cntDone + 1'b1;
      if (rspKind == RSP_DISC)  cntDisc  <= cntDisc + 1'b1;
    end
  end
endmodule

// File: rtl/delayed_read_target.sv
module delayed_read_target
  import drt_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int PREFETCH_BYTES = 64,
  parameter int DISCARD_CYCLES = 1024,
  parameter int CNT_W          = 16,
  localparam int WORDS = PREFETCH_BYTES / 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStart,
  input  logic              reqLast,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        rspKind,
  output logic [DATA_W-1:0] rspData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic [CNT_W-1:0]  cntRetry,
  output logic [CNT_W-1:0]  cntDone,
  output logic [CNT_W-1:0]  cntDisc
);
  dpStrobe_t strobe;
  rspKind_e  kind;
  logic      addrMatch, fillLast, rdEmpty;

  drt_ctrl #(.DISCARD_CYCLES(DISCARD_CYCLES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStart(reqStart), .reqLast(reqLast),
    .addrMatch(addrMatch), .fillLast(fillLast), .rdEmpty(rdEmpty),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .strobe(strobe),
    .rspKind(kind), .memReqValid(memReqValid),
    .cntRetry(cntRetry), .cntDone(cntDone), .cntDisc(cntDisc)
  );

  drt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .memRspData(memRspData),
    .pendAddr(memReqAddr), .addrMatch(addrMatch), .fillLast(fillLast),
    .rdEmpty(rdEmpty), .rdData(rspData)
  );

  assign rspKind = kind;
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqLast,
  input logic [1:0]        rspKind,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [CNT_W-1:0]  cntRetry,
  input logic [CNT_W-1:0]  cntDisc
);
  localparam int RUN_W = $clog2(WORDS + 2);
  logic [RUN_W-1:0] dataRun;

  always_ff @(posedge clk) begin
    if (!rstN) dataRun <= '0;
    else if (rspKind == 2'd3 || (rspKind == 2'd1 && reqLast)) dataRun <= '0;
    else if (rspKind == 2'd1) dataRun <= dataRun + 1'b1;
  end

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> rspKind == 2'd0);
  // R12
  beat_answered_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> rspKind != 2'd0);
  // R3
  fetch_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && memReqValid) |-> rspKind == 2'd2);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspKind == 2'd1 |-> dataRun < RUN_W'(WORDS));
  // R10
  retry_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cntRetry == $past(cntRetry) + CNT_W'($past(rspKind) == 2'd2));
  // R10
  disc_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cntDisc == $past(cntDisc) + CNT_W'($past(rspKind) == 2'd3));
endmodule

bind delayed_read_target drt_checker #(.ADDR_W(ADDR_W), .WORDS(WORDS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLast(reqLast), .rspKind(rspKind),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .cntRetry(cntRetry), .cntDisc(cntDisc)
);

// File: tb/delayed_read_target_tb.sv
module delayed_read_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 16;
  localparam int DISCARD    = 1024;
  localparam logic [1:0] K_NONE = 2'd0, K_DATA = 2'd1, K_RETRY = 2'd2, K_DISC = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStart = 1'b0, reqLast = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  rspKind;
  logic [31:0] rspData;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady = 1'b0, memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [15:0] cntRetry, cntDone, cntDisc;

  int checks = 0, failures = 0;
  int expRetry = 0, expDone = 0, expDisc = 0;
  int fetchReqs = 0, fetchDone = 0;
  logic [31:0] lastFetchAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delayed_read_target u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStart(reqStart), .reqLast(reqLast),
    .reqAddr(reqAddr), .rspKind(rspKind), .rspData(rspData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .cntRetry(cntRetry), .cntDone(cntDone), .cntDisc(cntDisc)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h1234};
  endfunction

  // memory model: accepts after two cycles, returns WORDS beats
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        repeat (2) @(negedge clk);
        memReqReady = 1'b1;
        lastFetchAddr = memReqAddr;
        fetchReqs++;
        @(negedge clk);
        memReqReady = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
          memRspValid = 1'b1;
          memRspData  = memWord(lastFetchAddr + 32'(4 * i));
          @(negedge clk);
        end
        memRspValid = 1'b0;
        fetchDone++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic s, input logic l, input logic [31:0] a,
                      input logic [1:0] expK, input logic [31:0] expD, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqStart = s; reqLast = l; reqAddr = a;
    #1;
    chk(rspKind == expK, tag, 32'(rspKind), 32'(expK));
    if (expK == K_DATA) chk(rspData == expD, tag, rspData, expD);
    if (expK == K_RETRY) expRetry++;
    if (expK == K_DATA && s) expDone++;
    if (expK == K_DISC) expDisc++;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqStart = 1'b0; reqLast = 1'b0;
  endtask

  task automatic checkFetchIssued(input logic [31:0] a, input string tag);
    @(negedge clk); #1;
    chk(memReqValid == 1'b1, tag, 32'(memReqValid), 32'd1);
    chk(memReqAddr == a, tag, memReqAddr, a);
  endtask

  task automatic waitFill(input int n);
    while (fetchDone < n) @(negedge clk);
  endtask

  task automatic testReset();
    #1;
    chk(rspKind == K_NONE, "R12 no request no response", 32'(rspKind), 0);
    chk(memReqValid == 1'b0, "R11 no fetch after reset", 32'(memReqValid), 0);
    chk(cntRetry == 0 && cntDone == 0 && cntDisc == 0, "R11 counters zero",
        32'(cntRetry) + 32'(cntDone) + 32'(cntDisc), 0);
  endtask

  task automatic testStray();
    beat(1'b0, 1'b0, 32'h80, K_RETRY, 0, "R12 stray continuation retried");
    repeat (4) @(negedge clk);
    chk(fetchReqs == 0, "R12 stray beat starts no fetch", fetchReqs, 0);
  endtask

  task automatic testFullBurst();
    beat(1'b1, 1'b0, 32'h100, K_RETRY, 0, "R1 first attempt retried");
    checkFetchIssued(32'h100, "R1 fetch at start address");
    beat(1'b1, 1'b0, 32'h100, K_RETRY, 0, "R3 same address retried in fetch");
    beat(1'b1, 1'b0, 32'h900, K_RETRY, 0, "R3 other address retried in fetch");
    waitFill(1);
    chk(lastFetchAddr == 32'h100, "R3 fetch address undisturbed", lastFetchAddr, 32'h100);
    beat(1'b1, 1'b0, 32'h100, K_DATA, memWord(32'h100), "R4 first word");
    for (int i = 1; i < WORDS; i++)
      beat(1'b0, 1'b0, 32'h100, K_DATA, memWord(32'h100 + 32'(4 * i)), "R5 next word");
    beat(1'b0, 1'b0, 32'h100, K_DISC, 0, "R5 disconnect after last word");
    chk(fetchReqs == 1, "R2 single fetch per transaction", fetchReqs, 1);
    beat(1'b1, 1'b0, 32'h140, K_RETRY, 0, "R6 next address retried");
    checkFetchIssued(32'h140, "R6 fresh fetch at next address");
    waitFill(2);
  endtask

  task automatic testMismatchAndLast();
    beat(1'b1, 1'b0, 32'h200, K_RETRY, 0, "R7 foreign address retried");
    repeat (4) @(negedge clk);
    chk(fetchReqs == 2, "R7 no fetch for foreign address", fetchReqs, 2);
    beat(1'b1, 1'b0, 32'h140, K_DATA, memWord(32'h140), "R7 buffer kept");
    beat(1'b0, 1'b1, 32'h140, K_DATA, memWord(32'h144), "R8 last beat data");
    beat(1'b1, 1'b0, 32'h140, K_RETRY, 0, "R8 buffer dropped after last");
    checkFetchIssued(32'h140, "R8 refetch after last");
    waitFill(3);
  endtask

  task automatic testDiscard();
    repeat (DISCARD - 100) @(negedge clk);
    beat(1'b1, 1'b1, 32'h140, K_DATA, memWord(32'h140), "R9 served before timeout");
    beat(1'b1, 1'b0, 32'h300, K_RETRY, 0, "R9 new request retried");
    waitFill(4);
    repeat (DISCARD + 50) @(negedge clk);
    beat(1'b1, 1'b0, 32'h300, K_RETRY, 0, "R9 expired buffer retried");
    checkFetchIssued(32'h300, "R9 refetch after discard");
    waitFill(5);
  endtask

  task automatic testCounters();
    @(negedge clk); #1;
    chk(cntRetry == 16'(expRetry), "R10 retry count", 32'(cntRetry), expRetry);
    chk(cntDone == 16'(expDone), "R10 completion count", 32'(cntDone), expDone);
    chk(cntDisc == 16'(expDisc), "R10 disconnect count", 32'(cntDisc), expDisc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testStray();
    testFullBurst();
    testMismatchAndLast();
    testDiscard();
    testCounters();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule